// File: doc/BRIEF.md
# Double-Buffered PWM Timer

This block produces one pulse-width-modulated output from an up-counting timer. Software sets two 32-bit values through a byte-addressed register port: a period limit and a compare threshold. The output is high from the start of each period until the counter reaches the compare threshold. The counter runs from zero up to the period limit, so one period lasts limit + 1 clocks.

Each value has two copies. The active copy drives the counter and the output. The shadow copy is written while the timer is running. A write to a shadow register raises a pending flag. At the next period boundary both shadow values are copied into the active pair in the same cycle, and the flag drops. The period in progress therefore always finishes with the settings it started with. When the timer is stopped, software writes the active registers directly.

A 16-bit control register holds a counter-run bit and a waveform-enable bit. It also holds a two-bit synchronisation field, which is stored and read back but drives no logic. The register port is plain: a write strobe with address and data, and a read-data bus that follows the address combinationally. It has no valid/ready handshake because every access completes in one cycle.

Top module: `shadow_pwm_timer`

## Requirements
- R1: After reset all registers read zero, the counter is zero and the output is low.
- R2: Register offsets are fixed: active period 0x08, active compare 0x0C, shadow period 0x10, shadow compare 0x14, control 0x2A. The control register reads back all 16 written bits. Any other address reads zero and ignores writes.
- R3: While control bit 4 (run) is set, the counter starts at zero and advances by one each clock. On the clock after it reaches or passes the active period value, it returns to zero. While bit 4 is clear, the counter is held at zero.
- R4: With bits 4 and 9 both set, the output is high exactly while the counter is below the active compare value. A compare of zero keeps the output low. A compare above the period keeps the output high for the whole period.
- R5: The output is low whenever control bit 9 (waveform enable) or bit 4 is clear, even if the counter is running.
- R6: A shadow write leaves both active registers unchanged until the next period boundary.
- R7: At a period boundary with the pending flag set, both shadow values are copied to the active registers and the flag clears. Later boundaries copy nothing until a new shadow write occurs.
- R8: A write to an active register takes effect on the next clock, even while running. It overrides a transfer in the same cycle.
- R9: Period 1 with compare 1 is legal and gives an output that alternates one clock high and one clock low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr`, combinational |
| pwm_out | output | 1 | PWM waveform |

## Verification
A stuck pending flag or a wrong boundary test shows up on the output within one period: the high time follows the old compare value, or the period length follows the old limit. A transfer that fires too early shows up as a changed active register readback in the middle of a period. A counter that fails to clear when stopped shows up in the first cycle after restart, because the output must go high immediately whenever the compare value is non-zero.

// File: rtl/pwm_timer_pkg.sv
`timescale 1ns/1ps
package pwm_timer_pkg;
  localparam int unsigned OFS_ACT_PER = 32'h08;
  localparam int unsigned OFS_ACT_CMP = 32'h0C;
  localparam int unsigned OFS_SH_PER  = 32'h10;
  localparam int unsigned OFS_SH_CMP  = 32'h14;
  localparam int unsigned OFS_CTRL    = 32'h2A;
  localparam int unsigned BIT_RUN     = 4;
  localparam int unsigned BIT_WAVE    = 9;
  localparam int unsigned NUM_PAIRS   = 2;   // period, compare
endpackage

// File: rtl/pwm_regs.sv
`timescale 1ns/1ps
module pwm_regs
  import pwm_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6,
  parameter int CTRL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wrap,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] act_per,
  output logic [DATA_W-1:0] act_cmp,
  output logic [DATA_W-1:0] sh_per,
  output logic [DATA_W-1:0] sh_cmp,
  output logic              run,
  output logic              wave_en,
  output logic              pending
);
  localparam int PAD_W = DATA_W - CTRL_W;

  logic [NUM_PAIRS-1:0][DATA_W-1:0] act_v, sh_v;
  logic [CTRL_W-1:0]                ctrl_q;
  logic                             pend_q;
  logic                             sh_wr_any;

  assign sh_wr_any = wr_en && ((addr == ADDR_W'(OFS_SH_PER)) ||
                               (addr == ADDR_W'(OFS_SH_CMP)));

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    localparam int unsigned AO = (g == 0) ? OFS_ACT_PER : OFS_ACT_CMP;
    localparam int unsigned SO = (g == 0) ? OFS_SH_PER  : OFS_SH_CMP;
    logic [DATA_W-1:0] act_r, sh_r;
    logic              act_hit, sh_hit;

    assign act_hit = wr_en && (addr == ADDR_W'(AO));
    assign sh_hit  = wr_en && (addr == ADDR_W'(SO));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_r <= '0;
        sh_r  <= '0;
      end else begin
        if (sh_hit) sh_r <= wdata;
        // direct write wins over a boundary transfer
        if (act_hit)              act_r <= wdata;
        else if (wrap && pend_q)  act_r <= sh_r;
      end
    end

    assign act_v[g] = act_r;
    assign sh_v[g]  = sh_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ctrl_q <= '0;
    end else begin
      if (sh_wr_any)  pend_q <= 1'b1;
      else if (wrap)  pend_q <= 1'b0;
      if (wr_en && (addr == ADDR_W'(OFS_CTRL))) ctrl_q <= wdata[CTRL_W-1:0];
    end
  end

  always_comb begin
    case (addr)
      ADDR_W'(OFS_ACT_PER): rdata = act_v[0];
      ADDR_W'(OFS_ACT_CMP): rdata = act_v[1];
      ADDR_W'(OFS_SH_PER):  rdata = sh_v[0];
      ADDR_W'(OFS_SH_CMP):  rdata = sh_v[1];
      ADDR_W'(OFS_CTRL):    rdata = {{PAD_W{1'b0}}, ctrl_q};
      default:              rdata = '0;
    endcase
  end

  assign act_per = act_v[0];
  assign act_cmp = act_v[1];
  assign sh_per  = sh_v[0];
  assign sh_cmp  = sh_v[1];
  assign run     = ctrl_q[BIT_RUN];
  assign wave_en = ctrl_q[BIT_WAVE];
  assign pending = pend_q;
endmodule

// File: rtl/pwm_counter.sv
`timescale 1ns/1ps
module pwm_counter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [DATA_W-1:0] limit,
  output logic [DATA_W-1:0] cnt,
  output logic              wrap
);
  // >= so that a limit lowered mid-period still ends the period
  assign wrap = run && (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || wrap)  cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pwm_wave.sv
`timescale 1ns/1ps
module pwm_wave #(
  parameter int DATA_W = 32
) (
  input  logic              run,
  input  logic              wave_en,
  input  logic [DATA_W-1:0] cnt,
  input  logic [DATA_W-1:0] cmp,
  output logic              pwm_out
);
  assign pwm_out = run && wave_en && (cnt < cmp);
endmodule

// File: rtl/shadow_pwm_timer.sv
`timescale 1ns/1ps
module shadow_pwm_timer #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6,
  parameter int CTRL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              pwm_out
);
  logic [DATA_W-1:0] act_per, act_cmp, sh_per, sh_cmp, cnt;
  logic              run, wave_en, pending, wrap;

  pwm_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_W(CTRL_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .wrap(wrap), .rdata(rdata), .act_per(act_per), .act_cmp(act_cmp),
    .sh_per(sh_per), .sh_cmp(sh_cmp), .run(run), .wave_en(wave_en),
    .pending(pending)
  );

  pwm_counter #(.DATA_W(DATA_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .run(run), .limit(act_per),
    .cnt(cnt), .wrap(wrap)
  );

  pwm_wave #(.DATA_W(DATA_W)) wave_i (
    .run(run), .wave_en(wave_en), .cnt(cnt), .cmp(act_cmp),
    .pwm_out(pwm_out)
  );
endmodule

// File: rtl/shadow_pwm_timer_chk.sv
`timescale 1ns/1ps
module shadow_pwm_timer_chk
  import pwm_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              run,
  input logic              wave_en,
  input logic [DATA_W-1:0] cnt,
  input logic              wrap,
  input logic              pending,
  input logic [DATA_W-1:0] act_per,
  input logic [DATA_W-1:0] act_cmp,
  input logic [DATA_W-1:0] sh_per,
  input logic [DATA_W-1:0] sh_cmp,
  input logic              pwm_out
);
  logic act_wr, sh_wr;
  assign act_wr = wr_en && ((addr == ADDR_W'(OFS_ACT_PER)) || (addr == ADDR_W'(OFS_ACT_CMP)));
  assign sh_wr  = wr_en && ((addr == ADDR_W'(OFS_SH_PER))  || (addr == ADDR_W'(OFS_SH_CMP)));

  // R5
  out_low_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run || !wave_en) |-> !pwm_out);

  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));

  // R3
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (cnt >= act_per)) |=> (cnt == '0));

  // R6
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap && !act_wr) |=> ($stable(act_per) && $stable(act_cmp)));

  // R7
  transfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && pending && !act_wr) |=> ((act_per == $past(sh_per)) && (act_cmp == $past(sh_cmp))));

  // R7
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !sh_wr) |=> !pending);
endmodule

bind shadow_pwm_timer shadow_pwm_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .run(run),
  .wave_en(wave_en), .cnt(cnt), .wrap(wrap), .pending(pending),
  .act_per(act_per), .act_cmp(act_cmp), .sh_per(sh_per), .sh_cmp(sh_cmp),
  .pwm_out(pwm_out)
);

// File: tb/shadow_pwm_timer_tb_top.sv
`timescale 1ns/1ps
module shadow_pwm_timer_tb_top;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 6;
  localparam logic [ADDR_W-1:0] A_APER = 6'h08, A_ACMP = 6'h0C,
                                A_SPER = 6'h10, A_SCMP = 6'h14,
                                A_CTRL = 6'h2A, A_NONE = 6'h04;
  localparam logic [31:0] C_START = 32'h02D0, C_STOP = 32'h00C0,
                          C_NOWAVE = 32'h00D0;
  localparam int NVEC = 6;
  // {period, compare}
  localparam logic [63:0] VEC [NVEC] = '{
    {32'd5, 32'd2}, {32'd1, 32'd1}, {32'd3, 32'd0},
    {32'd3, 32'd7}, {32'd7, 32'd7}, {32'd10, 32'd4}};

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0, rdata;
  logic pwm_out;
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  shadow_pwm_timer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pwm_out(pwm_out));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic chk_reg(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] d;
    rd(a, d);
    check(d == exp, tag, d, exp);
  endtask

  initial begin
    logic [31:0] d;
    tick(3);
    // R1: reset state
    check(pwm_out == 1'b0, "R1 out in reset", 32'(pwm_out), 0);
    rst_n = 1'b1;
    tick(2);
    check(pwm_out == 1'b0, "R1 out after reset", 32'(pwm_out), 0);
    chk_reg(A_APER, 0, "R1 active period");
    chk_reg(A_SCMP, 0, "R1 shadow compare");
    chk_reg(A_CTRL, 0, "R1 control");

    // R2: control readback and unmapped address
    bus_write(A_CTRL, 32'hFFFF);
    chk_reg(A_CTRL, 32'hFFFF, "R2 ctrl readback all bits");
    bus_write(A_CTRL, C_STOP);
    bus_write(A_APER, 32'h1234);
    bus_write(A_NONE, 32'hDEADBEEF);
    chk_reg(A_NONE, 0, "R2 unmapped reads zero");
    chk_reg(A_APER, 32'h1234, "R2 unmapped write ignored");
    chk_reg(A_SPER, 0, "R2 shadow untouched");

    // R3 R4 R9: table of waveform vectors, two periods each
    for (int v = 0; v < NVEC; v++) begin
      int p, c, bad;
      p = int'(VEC[v][63:32]); c = int'(VEC[v][31:0]); bad = 0;
      bus_write(A_CTRL, C_STOP);
      bus_write(A_APER, 32'(p));
      bus_write(A_ACMP, 32'(c));
      bus_write(A_CTRL, C_START);
      for (int i = 0; i < 2 * (p + 1); i++) begin
        bit exp;
        exp = ((i % (p + 1)) < c);
        if (pwm_out !== exp) bad++;
        tick();
      end
      check(bad == 0, (p == 1) ? "R9 minimum setting" : "R3 R4 waveform vector",
            32'(bad), 0);
    end

    // R6 R7: shadow update in mid-period (period 5, compare 2)
    bus_write(A_CTRL, C_STOP);
    bus_write(A_APER, 5);
    bus_write(A_ACMP, 2);
    bus_write(A_CTRL, C_START);                      // i=0, cnt 0
    check(pwm_out == 1'b1, "R4 high at start", 32'(pwm_out), 1);
    bus_write(A_SPER, 3);                            // i=1
    bus_write(A_SCMP, 3);                            // i=2
    chk_reg(A_APER, 5, "R6 period held after shadow write");
    chk_reg(A_ACMP, 2, "R6 compare held after shadow write");
    check(pwm_out == 1'b0, "R6 old compare still in force", 32'(pwm_out), 0);
    tick(3);                                         // i=5, last clock of period
    chk_reg(A_APER, 5, "R6 period held to boundary");
    tick();                                          // i=6, new period
    chk_reg(A_APER, 3, "R7 period transferred");
    chk_reg(A_ACMP, 3, "R7 compare transferred");
    check(pwm_out == 1'b1, "R7 new period starts high", 32'(pwm_out), 1);
    tick(3);                                         // i=9, cnt 3 == compare
    check(pwm_out == 1'b0, "R7 new compare used", 32'(pwm_out), 0);
    tick();                                          // i=10, cnt 0 (period 4)
    check(pwm_out == 1'b1, "R7 new period length", 32'(pwm_out), 1);

    // R8: active write while running acts at once
    bus_write(A_ACMP, 1);                            // i=11, cnt 1
    check(pwm_out == 1'b0, "R8 immediate compare", 32'(pwm_out), 0);
    bus_write(A_APER, 4);                            // i=12, cnt 2
    tick(4);                                         // i=16, past a boundary
    chk_reg(A_APER, 4, "R7 no recopy after pending cleared");

    // R5 R3: stop clears counter and output
    bus_write(A_CTRL, C_STOP);
    check(pwm_out == 1'b0, "R5 low when stopped", 32'(pwm_out), 0);
    chk_reg(A_CTRL, C_STOP, "R2 sync field kept");
    tick(3);
    bus_write(A_CTRL, C_START);
    check(pwm_out == 1'b1, "R3 restart from zero", 32'(pwm_out), 1);
    tick();
    check(pwm_out == 1'b0, "R3 restart second cycle", 32'(pwm_out), 0);

    // R5: counter running, waveform disabled
    bus_write(A_CTRL, C_NOWAVE);
    begin
      int highs = 0;
      for (int i = 0; i < 8; i++) begin
        if (pwm_out) highs++;
        tick();
      end
      check(highs == 0, "R5 low with waveform off", 32'(highs), 0);
    end
    rd(A_CTRL, d);
    check(d == C_NOWAVE, "R2 ctrl readback", d, C_NOWAVE);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule